// File: doc/BRIEF.md
# Isolated Supply Soft-Start Sequencer

This block brings up a galvanically isolated supply whose transformer is fed by an audio-frequency drive chain. It generates the drive waveform with a phase accumulator and begins at a high drive frequency. At fixed intervals it lowers the accumulator increment by a fixed amount, until it reaches the increment that gives the final 48 Hz drive. Because the drive starts high and glides down, the isolated secondary rises slowly. The power stage then does not trip its overload shutdown and restart in a loop when it meets the inrush current at start-up.

The block also times two rail enables from the moment its logic-supply-stable input goes high. The oven heater of the voltage reference is enabled first, after a long fixed delay. The low-noise amplifier rail follows after a second fixed delay. If the stable input falls, both enables drop and the frequency glide starts again from the beginning. Every time constant is a parameter counted in clock cycles, so a bench can run the whole sequence in compressed time.

A ready output reports that the glide has ended and both rails are on. The stable input is taken as already synchronous to `clk`.

Top module: `iso_softstart`

## Requirements
- R1: While `rst` is high, or while `pwr_stable` is low, `drv_phase` is 0, `drv_sq` is 0, and `ref_heat_en`, `lna_rail_en` and `seq_ready` are all 0.
- R2: On every clock edge with `pwr_stable` high, the internal ACC_W-bit accumulator adds the increment in force before that edge, modulo 2^ACC_W. `drv_phase` is the top PHASE_W bits of the accumulator, and `drv_sq` is its most significant bit.
- R3: On the first edge after `pwr_stable` rises, the accumulator advances by exactly INC_START.
- R4: With `pwr_stable` held high, the increment drops by INC_STEP on every edge whose count since the rise is a multiple of STEP_CYCLES. The increment is clamped at INC_FINAL, so it never falls below INC_FINAL, and it never changes on any other edge.
- R5: Once the increment equals INC_FINAL, it stays at INC_FINAL for as long as `pwr_stable` stays high.
- R6: `ref_heat_en` goes high after exactly HEAT_DELAY edges with `pwr_stable` high, and stays high while `pwr_stable` stays high.
- R7: `lna_rail_en` goes high AMP_DELAY edges after `ref_heat_en`, that is after HEAT_DELAY+AMP_DELAY edges. It is never high while `ref_heat_en` is low.
- R8: An edge that samples `pwr_stable` low clears both enables and the accumulator at that edge. It also resets the increment to INC_START and the time base to zero, so a low pulse of a single cycle restarts the whole sequence.
- R9: `seq_ready` is high exactly when the increment equals INC_FINAL and both enables are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_stable | input | 1 | Logic supply reported stable (synchronous) |
| drv_sq | output | 1 | Square-wave drive, the accumulator MSB |
| drv_phase | output | PHASE_W | Top bits of the drive phase accumulator |
| ref_heat_en | output | 1 | Reference oven heater enable |
| lna_rail_en | output | 1 | Low-noise amplifier supply enable |
| seq_ready | output | 1 | Glide finished and both rails enabled |

## Verification
Two events can fall on the same edge. The last downward step of the increment, which lands on the final value, can coincide with the heater enable. A drop of the stable input can also coincide with an edge that would have taken a step. The bench sets its compressed parameters so that the fifth and final step comes on edge 40, the same edge as the heater delay. It then checks on that edge that the phase advance, `ref_heat_en` and the still-low `seq_ready` all match the model. In a second scenario it drops `pwr_stable` exactly on edge 24, a step boundary. After the input returns, the first advance must equal INC_START and not a stepped-down value.

// File: rtl/iso_softstart_pkg.sv
package iso_softstart_pkg;

    // Enables for the two staggered rails.
    typedef struct packed {
        logic heat;
        logic amp;
    } rail_en_t;

    // One downward glide step, clamped at the floor value (widths up to 32).
    function automatic logic [31:0] glide_down(
        input logic [31:0] cur,
        input logic [31:0] dec,
        input logic [31:0] floor_v
    );
        if (cur <= floor_v)
            return floor_v;
        if ((cur - floor_v) > dec)
            return cur - dec;
        return floor_v;
    endfunction

endpackage

// File: rtl/iso_ramp_gen.sv
module iso_ramp_gen
    import iso_softstart_pkg::*;
#(
    parameter int unsigned ACC_W       = 32,
    parameter int unsigned INC_START   = 85899,
    parameter int unsigned INC_FINAL   = 4123,
    parameter int unsigned INC_STEP    = 2000,
    parameter int unsigned STEP_CYCLES = 5000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [ACC_W-1:0] inc,
    output logic             at_final
);
    localparam int unsigned     TW      = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [TW-1:0]   T_LAST  = TW'(STEP_CYCLES - 1);
    localparam logic [ACC_W-1:0] START_V = ACC_W'(INC_START);
    localparam logic [ACC_W-1:0] FINAL_V = ACC_W'(INC_FINAL);

    logic [TW-1:0]    tick_q;
    logic [ACC_W-1:0] inc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_q <= '0;
            inc_q  <= START_V;
        end else if (tick_q == T_LAST) begin
            tick_q <= '0;
            inc_q  <= ACC_W'(glide_down(32'(inc_q), 32'(INC_STEP), 32'(INC_FINAL)));
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign inc      = inc_q;
    assign at_final = (inc_q == FINAL_V);

    // R4: the clamp holds the increment at or above the floor
    a_r4_inc_floor: assert property (@(posedge clk) disable iff (rst)
        inc_q >= FINAL_V);

    // R4: the increment moves only on an interval boundary
    a_r4_step_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run) && ($past(tick_q) != T_LAST)) |-> $stable(inc_q));

    // R5: once final, stays final while running
    a_r5_final_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run) && $past(at_final)) |-> at_final);

    // R3: a stopped ramp always sits at its start value
    a_r3_restart_value: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run)) |-> (inc_q == START_V));

endmodule

// File: rtl/iso_phase_acc.sv
module iso_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            acc_q <= '0;
        else
            acc_q <= acc_q + inc;
    end

    assign acc = acc_q;

    // R2: each running edge advances by the increment supplied by the ramp
    a_r2_phase_advance: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run)) |-> (acc_q == ($past(acc_q) + $past(inc))));

    // R8: a stopped accumulator is cleared
    a_r8_acc_cleared: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run)) |-> (acc_q == '0));

endmodule

// File: rtl/iso_rail_delay.sv
module iso_rail_delay
    import iso_softstart_pkg::*;
#(
    parameter int unsigned HEAT_DELAY = 500000000,
    parameter int unsigned AMP_DELAY  = 100000000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    output rail_en_t en
);
    localparam int unsigned   TOTAL    = HEAT_DELAY + AMP_DELAY;
    localparam int unsigned   CW       = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] TOP      = CW'(TOTAL);
    localparam logic [CW-1:0] HEAT_LIM = CW'(HEAT_DELAY - 1);
    localparam logic [CW-1:0] AMP_LIM  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] HEAT_AT  = CW'(HEAT_DELAY);

    logic [CW-1:0] cnt_q;
    rail_en_t      en_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            en_q  <= '0;
        end else begin
            if (cnt_q != TOP)
                cnt_q <= cnt_q + 1'b1;
            en_q.heat <= (cnt_q >= HEAT_LIM);
            en_q.amp  <= (cnt_q >= AMP_LIM);
        end
    end

    assign en = en_q;

    // R7: the amplifier rail never runs without the heater
    a_r7_amp_needs_heat: assert property (@(posedge clk) disable iff (rst)
        en_q.amp |-> en_q.heat);

    // R8: a stopped sequence holds both rails off
    a_r8_drop_clears: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run)) |-> (en_q == '0));

    // R6: the heater turns on exactly at the heater delay
    a_r6_heat_on_time: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q.heat) |-> (cnt_q == HEAT_AT));

    // R7: the amplifier rail turns on once the full delay has elapsed
    a_r7_amp_on_time: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q.amp) |-> (cnt_q == TOP));

endmodule

// File: rtl/iso_softstart.sv
module iso_softstart
    import iso_softstart_pkg::*;
#(
    parameter int unsigned ACC_W       = 32,
    parameter int unsigned PHASE_W     = 10,
    parameter int unsigned INC_START   = 85899,
    parameter int unsigned INC_FINAL   = 4123,
    parameter int unsigned INC_STEP    = 2000,
    parameter int unsigned STEP_CYCLES = 5000000,
    parameter int unsigned HEAT_DELAY  = 500000000,
    parameter int unsigned AMP_DELAY   = 100000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_stable,
    output logic               drv_sq,
    output logic [PHASE_W-1:0] drv_phase,
    output logic               ref_heat_en,
    output logic               lna_rail_en,
    output logic               seq_ready
);
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] acc;
    logic             at_final;
    rail_en_t         rails;

    iso_ramp_gen #(
        .ACC_W      (ACC_W),
        .INC_START  (INC_START),
        .INC_FINAL  (INC_FINAL),
        .INC_STEP   (INC_STEP),
        .STEP_CYCLES(STEP_CYCLES)
    ) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .run     (pwr_stable),
        .inc     (inc),
        .at_final(at_final)
    );

    iso_phase_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk(clk),
        .rst(rst),
        .run(pwr_stable),
        .inc(inc),
        .acc(acc)
    );

    iso_rail_delay #(
        .HEAT_DELAY(HEAT_DELAY),
        .AMP_DELAY (AMP_DELAY)
    ) u_rails (
        .clk(clk),
        .rst(rst),
        .run(pwr_stable),
        .en (rails)
    );

    assign drv_sq      = acc[ACC_W-1];
    assign drv_phase   = acc[ACC_W-1 -: PHASE_W];
    assign ref_heat_en = rails.heat;
    assign lna_rail_en = rails.amp;
    assign seq_ready   = at_final & rails.heat & rails.amp;

    // R9: readiness persists while the stable input stays high
    a_r9_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(seq_ready) && $past(pwr_stable)) |-> seq_ready);

    // R1: no output activity while the stable input is low
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pwr_stable)) |-> (!drv_sq && !ref_heat_en && !lna_rail_en && !seq_ready));

endmodule

// File: tb/iso_softstart_bench.sv
`timescale 1ns/1ps
module iso_softstart_bench;

    localparam int ACC_W   = 16;
    localparam int START   = 1000;
    localparam int FINAL   = 300;
    localparam int SZ      = 150;
    localparam int STEP    = 8;
    localparam int HEAT    = 40;
    localparam int AMP     = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwr_stable = 1'b0;
    logic              drv_sq;
    logic [ACC_W-1:0]  drv_phase;
    logic              ref_heat_en;
    logic              lna_rail_en;
    logic              seq_ready;

    int checks = 0;
    int errors = 0;
    int k = 0;
    logic [ACC_W-1:0] prev_phase = '0;

    always #2 clk = ~clk;

    iso_softstart #(
        .ACC_W      (ACC_W),
        .PHASE_W    (ACC_W),
        .INC_START  (START),
        .INC_FINAL  (FINAL),
        .INC_STEP   (SZ),
        .STEP_CYCLES(STEP),
        .HEAT_DELAY (HEAT),
        .AMP_DELAY  (AMP)
    ) u_iso_softstart (
        .clk        (clk),
        .rst        (rst),
        .pwr_stable (pwr_stable),
        .drv_sq     (drv_sq),
        .drv_phase  (drv_phase),
        .ref_heat_en(ref_heat_en),
        .lna_rail_en(lna_rail_en),
        .seq_ready  (seq_ready)
    );

    function automatic int exp_inc(input int j);
        int v;
        v = START - (j / STEP) * SZ;
        if (v < FINAL) v = FINAL;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s k=%0d actual=%0d expected=%0d", req, what, k, act, exp);
        end
    endtask

    // One clock edge, then compare every output against the model.
    task automatic step(input string idle_tag);
        logic [ACC_W-1:0] d;
        string tag;
        @(posedge clk);
        if (rst || !pwr_stable) k = 0; else k++;
        @(negedge clk);
        if (k == 0) begin
            chk(drv_phase == '0, idle_tag, "phase", int'(drv_phase), 0);
            chk(!drv_sq, idle_tag, "square", int'(drv_sq), 0);
        end else begin
            d = drv_phase - prev_phase;
            if (k == 1) tag = "R3";
            else if (exp_inc(k - 1) == FINAL) tag = "R5";
            else tag = "R4";
            chk(d == ACC_W'(exp_inc(k - 1)), tag, "phase advance", int'(d), exp_inc(k - 1));
            chk(drv_sq == drv_phase[ACC_W-1], "R2", "square", int'(drv_sq), int'(drv_phase[ACC_W-1]));
        end
        chk(ref_heat_en == (k >= HEAT), (k == 0) ? idle_tag : "R6", "heat_en",
            int'(ref_heat_en), int'(k >= HEAT));
        chk(lna_rail_en == (k >= HEAT + AMP), (k == 0) ? idle_tag : "R7", "lna_en",
            int'(lna_rail_en), int'(k >= HEAT + AMP));
        chk(seq_ready == (k >= HEAT + AMP && exp_inc(k) == FINAL), (k == 0) ? idle_tag : "R9",
            "ready", int'(seq_ready), int'(k >= HEAT + AMP && exp_inc(k) == FINAL));
        prev_phase = drv_phase;
    endtask

    task automatic run_steps(input int n, input string idle_tag);
        for (int i = 0; i < n; i++) step(idle_tag);
    endtask

    // R1: reset dominates a high stable input; idle while input low
    task automatic t_reset_idle();
        rst = 1'b1;
        pwr_stable = 1'b1;
        run_steps(3, "R1");
        @(negedge clk);
        pwr_stable = 1'b0;
        rst = 1'b0;
        run_steps(4, "R1");
    endtask

    // R3 R4 R6 R7 R9: full sequence; edge 40 carries final step and heater
    task automatic t_full_sequence();
        pwr_stable = 1'b1;
        run_steps(75, "R1");
    endtask

    // R5: long hold at the final frequency
    task automatic t_hold_final();
        run_steps(40, "R5");
    endtask

    // R8: drop with heater on and amp rail still off
    task automatic t_drop_mid();
        pwr_stable = 1'b0;
        run_steps(2, "R8");
        pwr_stable = 1'b1;
        run_steps(50, "R8");
        pwr_stable = 1'b0;
        run_steps(1, "R8");
    endtask

    // R8: drop on the edge that would take a glide step
    task automatic t_drop_on_step();
        pwr_stable = 1'b1;
        run_steps(23, "R8");
        pwr_stable = 1'b0;
        run_steps(1, "R8");
        pwr_stable = 1'b1;
        run_steps(12, "R8");
    endtask

    // R8: a single-cycle low after ready restarts everything
    task automatic t_glitch_restart();
        run_steps(60, "R8");
        pwr_stable = 1'b0;
        run_steps(1, "R8");
        pwr_stable = 1'b1;
        run_steps(65, "R8");
    endtask

    initial begin
        t_reset_idle();
        t_full_sequence();
        t_hold_final();
        t_drop_mid();
        t_drop_on_step();
        t_glitch_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule